// File: doc/BRIEF.md
# Alpha-Blended Variable-Width Glyph Scanline Renderer

This block turns one scanline of text cells into a stream of RGB pixels. For each cell it receives a descriptor: the eight bytes of the cell's current row taken from its 64-byte character block, a mode bit, a foreground colour, a background colour and a visible width. In byte mode a row holds eight pixels of eight bits each. In packed mode the same eight bytes hold sixteen pixels of four bits each. Every pixel value acts as an alpha fade between the two colours of the cell, so anti-aliased text needs no palette slots for its intermediate shades.

The visible width trims columns from the right of each cell, and the first pixel of the next cell follows directly after the last drawn column. Proportional glyphs therefore pack tightly. A small state machine with two states, `ST_IDLE` (waiting for a cell) and `ST_EMIT` (sending the visible columns of the held cell), moves through the columns and gives one pixel per clock under valid/ready flow control. There are three transitions. *Load* goes from `ST_IDLE` to `ST_EMIT` when a cell with a nonzero visible width is accepted. *Chain* stays in `ST_EMIT` when the last pixel is taken in the same cycle that a new nonzero-width cell is accepted. *Drain* goes from `ST_EMIT` to `ST_IDLE` when the last pixel is taken and no such cell arrives. A zero-width cell is accepted and leaves the state as it was.

Top module: `glyph_alpha_renderer`

## Requirements
- R1: After reset, `pix_valid` is low and `cell_ready` is high.
- R2: In byte mode (`cell_nibble`=0), column c (c = 0 to 7, leftmost 0) takes its 8-bit alpha from `cell_row[8c+7:8c]`.
- R3: In packed mode (`cell_nibble`=1), column c (c = 0 to 15) uses byte c/2 of `cell_row`. The low nibble is used for even c and the high nibble for odd c. The 4-bit value n becomes the 8-bit alpha {n,n}.
- R4: Each 8-bit component of the output equals (bg·(255−a) + fg·a + 127) / 255, rounded down after the +127. So alpha 0xFF gives fg, 0x00 gives bg, and 0x80 with fg=255 and bg=0 gives 128. `pix_rgb`, `cell_fg` and `cell_bg` carry red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: A cell of visible width w produces exactly w pixels, columns 0 to w−1 in order. A cell with w=0 produces none. When w is odd in packed mode, the unused high nibble of the last byte is never shown.
- R6: A width larger than the mode's column count (8 in byte mode, 16 in packed mode) is clamped to that count.
- R7: Cells pack with no gap. `cell_ready` is high during `ST_EMIT` only in a cycle where the last pixel of the cell is being taken. A run of cells supplied without pause therefore gives one pixel on every clock.
- R8: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_rgb` and `pix_cell_end` hold their values into the next cycle.
- R9: `pix_cell_end` is high exactly on the last visible pixel of each cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Cell descriptor present |
| cell_ready | output | 1 | Descriptor accepted this cycle if valid |
| cell_nibble | input | 1 | 0: 8 pixels of 8 bits, 1: 16 pixels of 4 bits |
| cell_width | input | 5 | Visible columns, clamped to mode maximum |
| cell_fg | input | 24 | Foreground colour, RGB 8:8:8 |
| cell_bg | input | 24 | Background colour, RGB 8:8:8 |
| cell_row | input | 64 | Current row of the character block, byte 0 leftmost |
| pix_valid | output | 1 | Output pixel present |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_rgb | output | 24 | Blended pixel colour |
| pix_cell_end | output | 1 | Pixel is the last visible column of its cell |

## Verification
Some properties are checked by assertions on every cycle:
- The output holds steady under backpressure.
- A new cell is accepted mid-cell only together with the last pixel being taken.
- The column counter stays below the clamped width and wraps after a cell ends.
- Packed alpha values are nibble-replicated.
- Alpha 0x00 gives the background exactly and alpha 0xFF gives the foreground exactly.

Other behaviour only the bench scenarios can show:
- The blended value for every one of the 256 alpha codes and all 16 nibble codes.
- The exact pixel count for every width from 0 to 31 in both modes, including clamping and odd packed widths.
- Gap-free output across a chain of cells of mixed modes.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } glyph_state_e;

    localparam int COMP_W = 8;
    localparam int RGB_W  = 3 * COMP_W;
endpackage

// File: rtl/glyph_alpha_pick.sv
module glyph_alpha_pick #(
    parameter int ROW_BYTES = 8,
    parameter int COL_W     = $clog2(2 * ROW_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [8*ROW_BYTES-1:0]   row,
    input  logic                     nibble,
    input  logic [COL_W-1:0]         col,
    output logic [7:0]               alpha
);
    localparam int IDX_W = COL_W - 1;

    logic [IDX_W-1:0] idx;
    logic [7:0]       byte_sel;
    logic [3:0]       nib_sel;

    always_comb begin
        idx      = nibble ? col[COL_W-1:1] : col[IDX_W-1:0];
        byte_sel = row[8*idx +: 8];
        nib_sel  = col[0] ? byte_sel[7:4] : byte_sel[3:0];
        alpha    = nibble ? {nib_sel, nib_sel} : byte_sel;
    end

    AST_NIB_REPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        nibble |-> (alpha[7:4] == alpha[3:0])); // R3
endmodule

// File: rtl/glyph_blend_chan.sv
module glyph_blend_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fg,
    input  logic [7:0] bg,
    input  logic [7:0] alpha,
    output logic [7:0] out
);
    logic [16:0] mix;
    logic [16:0] quo;

    always_comb begin
        mix = 17'(bg) * 17'(8'd255 - alpha) + 17'(fg) * 17'(alpha);
        quo = (mix + 17'd127) / 17'd255;
        out = quo[7:0];
    end

    AST_ALPHA_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha == 8'hFF) |-> (out == fg)); // R4
    AST_ALPHA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha == 8'h00) |-> (out == bg)); // R4
endmodule

// File: rtl/glyph_alpha_renderer.sv
module glyph_alpha_renderer
    import glyph_pkg::*;
#(
    parameter int ROW_BYTES = 8,
    parameter int FULL_COLS = ROW_BYTES,
    parameter int NIB_COLS  = 2 * ROW_BYTES,
    parameter int WIDTH_W   = $clog2(NIB_COLS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cell_valid,
    output logic                   cell_ready,
    input  logic                   cell_nibble,
    input  logic [WIDTH_W-1:0]     cell_width,
    input  logic [23:0]            cell_fg,
    input  logic [23:0]            cell_bg,
    input  logic [8*ROW_BYTES-1:0] cell_row,
    output logic                   pix_valid,
    input  logic                   pix_ready,
    output logic [23:0]            pix_rgb,
    output logic                   pix_cell_end
);
    localparam int COL_W = $clog2(NIB_COLS);

    glyph_state_e           state_q, state_d;
    logic [COL_W-1:0]       col_q;
    logic [WIDTH_W-1:0]     limit_q;
    logic                   nib_q;
    logic [23:0]            fg_q, bg_q;
    logic [8*ROW_BYTES-1:0] row_q;

    logic [WIDTH_W-1:0]     limit_in;
    logic                   last_col;
    logic                   take_cell;
    logic [7:0]             alpha;

    // Clamp the requested width to the column count of the chosen mode
    always_comb begin
        if (cell_nibble)
            limit_in = (cell_width > WIDTH_W'(NIB_COLS)) ? WIDTH_W'(NIB_COLS) : cell_width;
        else
            limit_in = (cell_width > WIDTH_W'(FULL_COLS)) ? WIDTH_W'(FULL_COLS) : cell_width;
    end

    // Output process
    always_comb begin
        pix_valid    = (state_q == ST_EMIT);
        last_col     = pix_valid && (WIDTH_W'(col_q) == limit_q - 1'b1);
        pix_cell_end = last_col;
        cell_ready   = (state_q == ST_IDLE) || (last_col && pix_ready);
        take_cell    = cell_valid && cell_ready;
    end

    // Next-state logic: load, chain, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_cell && (limit_in != '0))
                    state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (pix_ready && last_col)
                    state_d = (take_cell && (limit_in != '0)) ? ST_EMIT : ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Cell holding registers and column counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            limit_q <= '0;
            nib_q   <= 1'b0;
            fg_q    <= '0;
            bg_q    <= '0;
            row_q   <= '0;
        end else if (take_cell) begin
            col_q   <= '0;
            limit_q <= limit_in;
            nib_q   <= cell_nibble;
            fg_q    <= cell_fg;
            bg_q    <= cell_bg;
            row_q   <= cell_row;
        end else if (pix_valid && pix_ready) begin
            col_q   <= col_q + 1'b1;
        end
    end

    glyph_alpha_pick #(
        .ROW_BYTES (ROW_BYTES),
        .COL_W     (COL_W)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .row    (row_q),
        .nibble (nib_q),
        .col    (col_q),
        .alpha  (alpha)
    );

    for (genvar k = 0; k < 3; k++) begin : g_chan
        glyph_blend_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .fg    (fg_q[8*k +: 8]),
            .bg    (bg_q[8*k +: 8]),
            .alpha (alpha),
            .out   (pix_rgb[8*k +: 8])
        );
    end

    AST_HOLD_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_rgb) && $stable(pix_cell_end))); // R8
    AST_TAKE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cell_ready) |-> (pix_ready && pix_cell_end)); // R7
    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (WIDTH_W'(col_q) < limit_q)); // R5
    AST_WRAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready && pix_cell_end) |=> (!pix_valid || (col_q == '0))); // R9
endmodule

// File: tb/glyph_alpha_renderer_tb.sv
module glyph_alpha_renderer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cell_valid;
    logic        cell_ready;
    logic        cell_nibble;
    logic [4:0]  cell_width;
    logic [23:0] cell_fg, cell_bg;
    logic [63:0] cell_row;
    logic        pix_valid;
    logic        pix_ready;
    logic [23:0] pix_rgb;
    logic        pix_cell_end;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ready_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [24:0] expq[$];
    int burst_cnt, t_first, t_last;
    bit held;
    logic [24:0] held_val;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    glyph_alpha_renderer u_dut (
        .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_ready(cell_ready),
        .cell_nibble(cell_nibble), .cell_width(cell_width), .cell_fg(cell_fg),
        .cell_bg(cell_bg), .cell_row(cell_row), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_rgb(pix_rgb), .pix_cell_end(pix_cell_end)
    );

    function automatic logic [7:0] mixc(input int f, input int b, input int a);
        return 8'((b * (255 - a) + f * a + 127) / 255);
    endfunction

    function automatic logic [23:0] exp_px(input bit nib, input logic [63:0] row,
                                           input int c, input logic [23:0] fg,
                                           input logic [23:0] bg);
        int a;
        logic [7:0] b;
        logic [23:0] r;
        if (nib) begin
            b = row[8*(c/2) +: 8];
            a = (c % 2) ? int'(b[7:4]) * 17 : int'(b[3:0]) * 17;
        end else begin
            a = int'(row[8*c +: 8]);
        end
        for (int k = 0; k < 3; k++)
            r[8*k +: 8] = mixc(int'(fg[8*k +: 8]), int'(bg[8*k +: 8]), a);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input bit nib, input int w, input logic [23:0] fg,
                        input logic [23:0] bg, input logic [63:0] row);
        int eff;
        int mx;
        mx  = nib ? 16 : 8;
        eff = (w > mx) ? mx : w;
        for (int c = 0; c < eff; c++)
            expq.push_back({(c == eff - 1), exp_px(nib, row, c, fg, bg)});
        forever begin
            @(negedge clk);
            cell_valid  = 1'b1;
            cell_nibble = nib;
            cell_width  = 5'(w);
            cell_fg     = fg;
            cell_bg     = bg;
            cell_row    = row;
            #1;
            if (cell_ready) begin
                @(posedge clk);
                break;
            end
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        cell_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Consumer and pixel checker
    initial begin
        pix_ready = 1'b1;
        held = 1'b0;
        forever begin
            @(negedge clk);
            pix_ready = ready_rand ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (rst_n && held)
                check("R8 held pixel", {pix_valid, pix_cell_end, pix_rgb}, {1'b1, held_val});
            held = 1'b0;
            if (rst_n && pix_valid) begin
                if (!pix_ready) begin
                    held = 1'b1;
                    held_val = {pix_cell_end, pix_rgb};
                end else if (expq.size() == 0) begin
                    check("R5 unexpected pixel", {pix_cell_end, pix_rgb}, 32'hFFFFFFFF);
                end else begin
                    check("R2/R3/R4/R5/R9 pixel", {pix_cell_end, pix_rgb}, expq[0]);
                    void'(expq.pop_front());
                    if (burst_cnt == 0) t_first = cyc;
                    t_last = cyc;
                    burst_cnt++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] row;
        int total;
        rst_n = 1'b0;
        cell_valid = 1'b0; cell_nibble = 1'b0; cell_width = '0;
        cell_fg = '0; cell_bg = '0; cell_row = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 pix_valid after reset", pix_valid, 0);
        check("R1 cell_ready after reset", cell_ready, 1);

        // R2 and R4: every 8-bit alpha code in byte mode, colours in both directions
        for (int i = 0; i < 32; i++) begin
            for (int k = 0; k < 8; k++) row[8*k +: 8] = 8'(8*i + k);
            send(1'b0, 8, (i % 2) ? 24'hFF00_40 : 24'h10_FF_80,
                 (i % 2) ? 24'h00_FF_C0 : 24'hF0_00_7F, row);
        end
        // R4 endpoints: 0xFF, 0x00, 0x80 between white and black
        send(1'b0, 3, 24'hFFFFFF, 24'h000000, 64'h0000_0000_0080_00FF);
        go_idle();
        drain();

        // R3: all nibble codes in both halves of the byte
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 8; k++) row[8*k +: 8] = {4'(15 - k - 8*(i%2)), 4'(k + 8*(i/2))};
            send(1'b1, 16, 24'hC8_32_FF, 24'h04_E0_10, row);
        end
        go_idle();
        drain();

        // R5 and R6: every width code in both modes, odd packed widths included
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 32; w++)
                send(m[0], w, 24'hFF_FF_FF, 24'h00_00_00, 64'h1F2E_3D4C_5B6A_7988);
        end
        go_idle();
        drain();

        // R7: a chain of cells gives one pixel every clock
        burst_cnt = 0;
        send(1'b0, 5, 24'h123456, 24'h654321, 64'h0123_4567_89AB_CDEF);
        send(1'b1, 16, 24'hABCDEF, 24'h102030, 64'hFEDC_BA98_7654_3210);
        send(1'b0, 1, 24'hFFFFFF, 24'h000000, 64'h0000_0000_0000_0080);
        send(1'b0, 8, 24'h00FF00, 24'hFF00FF, 64'h8040_2010_0804_0201);
        send(1'b1, 3, 24'h777777, 24'h222222, 64'h0000_0000_0000_F1A5);
        send(1'b0, 7, 24'h0000FF, 24'hFF0000, 64'hFFEE_DDCC_BBAA_9988);
        go_idle();
        drain();
        total = 5 + 16 + 1 + 8 + 3 + 7;
        check("R7 pixel count", burst_cnt, total);
        check("R7 gap-free span", t_last - t_first, total - 1);

        // R8: random backpressure over mixed cells
        ready_rand = 1'b1;
        for (int i = 0; i < 40; i++) begin
            row = {8{8'(37 * i + 11)}} ^ 64'h5A3C_9617_E24B_08D1;
            send(i[0], (i * 7) % 20, 24'(i * 24'h0B1D29), 24'(~(i * 24'h07F3A1)), row);
        end
        go_idle();
        drain();
        ready_rand = 1'b0;
        check("R5 queue drained", expq.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule